// File: doc/BRIEF.md
# Upstream High-Speed Detection Handshake

This block sits on the upstream-facing port of a hub and decides what a run of SE0 on the upstream lines means. The reset-detection wait depends on where the hub starts from. A suspended hub reacts after a short filter. A full-speed hub that is not suspended waits a longer window. A high-speed hub cannot tell reset from suspend directly, because high-speed idle is also SE0. It first drops back to full-speed terminations, lets the line settle, and then samples the bus again.

Once a reset is recognised, the block raises a one-cycle reset indication and asks the transceiver to drive a Chirp K of fixed length. It then watches for the host's alternating K-J chirp train. A complete train switches the port to high-speed. If the host never chirps, the block stays at full-speed when its listening window closes.

All timings are parameters counted in clock cycles. The integrator converts the line-timing limits into cycles for the clock in use. The chirp filter must be at least two cycles. The upstream line state arrives already decoded from the transceiver. The outputs are plain level and pulse requests, with no handshake.

Top module: `uhs_upstream_hs`

## Requirements
- R1: While reset is applied and after it is released, `chirp_k_o`, `hs_mode_o` and `bus_reset_o` are all low, and the block is in the full-speed idle state.
- R2: Line state is encoded as SE0=2'b00, J=2'b01, K=2'b10 and SE1=2'b11. With `suspended_i` high in full-speed idle, the SUSP_SE0_CYC-th consecutive SE0 sample starts the handshake. From the next cycle, `bus_reset_o` and `chirp_k_o` are high.
- R3: With `suspended_i` low in full-speed idle, the handshake starts on the FS_SE0_CYC-th consecutive SE0 sample. A shorter SE0 run produces neither reset nor chirp.
- R4: `bus_reset_o` is a single-cycle pulse that coincides with the first cycle of `chirp_k_o`. `chirp_k_o` stays high for exactly CHIRP_CYC cycles.
- R5: After its own chirp, the block enters high-speed when it sees the host sequence K,J,K,J,K,J, with each state held for at least FILT_CYC samples. `hs_mode_o` rises the cycle after the FILT_CYC-th sample of the final J. `chirp_k_o` is never high while `hs_mode_o` is high.
- R6: A state held for fewer than FILT_CYC samples is ignored. A held state that breaks the alternation restarts the count, and a held K counts as a new first K.
- R7: If no complete host sequence arrives within FALLBACK_CYC cycles after the chirp ends, the block returns to full-speed idle with `hs_mode_o` low. SE0 that continues without a break does not start another handshake.
- R8: In high-speed, HS_SE0_CYC consecutive SE0 samples drop `hs_mode_o` on the next cycle. SAMPLE_CYC samples later the line is sampled once. SE0 means reset, which raises the reset pulse and starts the chirp. Any other state means suspend: the block goes to full-speed idle and gives no reset pulse.
- R9: In high-speed, any non-SE0 sample restarts the SE0 count, so separate SE0 runs shorter than HS_SE0_CYC never leave high-speed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| line_st_i | input | 2 | Decoded upstream line state (SE0/J/K/SE1) |
| suspended_i | input | 1 | Hub is currently suspended |
| chirp_k_o | output | 1 | Request to drive Chirp K upstream |
| hs_mode_o | output | 1 | High-speed mode; selects high-speed terminations |
| bus_reset_o | output | 1 | One-cycle pulse when a bus reset is recognised |

## Verification
The embedded properties check, on every cycle, the bounded chirp length and the reset pulse arriving at chirp start. They also check that chirp and high-speed never overlap. High-speed may begin only after the detector reports a finished host sequence, and it may end only after an SE0 sample.

The choice between the three wait thresholds can only be shown by driven scenarios. The same holds for rejecting short glitches in the host train, for re-arming after a fallback during ongoing SE0, and for the reset-versus-suspend decision after reverting. The bench covers these with a cycle-level reference model.

// File: rtl/uhs_pkg.sv
package uhs_pkg;
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_e;

  typedef enum logic [2:0] {
    ST_FS_IDLE,
    ST_CHIRP,
    ST_WAIT_HOST,
    ST_HS_IDLE,
    ST_REVERT
  } hs_st_e;
endpackage

// File: rtl/uhs_se0_timer.sv
module uhs_se0_timer #(
  parameter int CNT_MAX = 41,
  parameter int W       = $clog2(CNT_MAX + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         is_se0_i,
  output logic [W-1:0] run_nx_o
);
  logic [W-1:0] run_q;

  // saturating count of consecutive SE0 samples, including this one
  always_comb begin
    if (!is_se0_i)                run_nx_o = '0;
    else if (run_q == W'(CNT_MAX)) run_nx_o = run_q;
    else                          run_nx_o = run_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) run_q <= '0;
    else         run_q <= run_nx_o;
  end
endmodule

// File: rtl/uhs_chirp_seq.sv
module uhs_chirp_seq
  import uhs_pkg::*;
#(
  parameter int FILT_CYC = 4,
  parameter int RW       = $clog2(FILT_CYC + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] line_i,
  output logic       done_o
);
  logic [1:0]    seg_q;
  logic [RW-1:0] run_q;
  logic [2:0]    cnt_q;
  logic          same, qual;
  logic [1:0]    want;

  assign same   = (line_i == seg_q);
  assign qual   = en_i && same && (run_q == RW'(FILT_CYC - 1));
  assign want   = cnt_q[0] ? LS_J : LS_K;
  assign done_o = qual && (line_i == want) && (cnt_q == 3'd5);

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !en_i) begin
      seg_q <= LS_SE1;
      run_q <= '0;
      cnt_q <= '0;
    end else begin
      if (!same) begin
        seg_q <= line_i;
        run_q <= RW'(1);
      end else if (run_q != RW'(FILT_CYC)) begin
        run_q <= run_q + 1'b1;
      end
      if (qual) begin
        if (line_i == want)       cnt_q <= cnt_q + 1'b1;
        else if (line_i == LS_K)  cnt_q <= 3'd1;
        else                      cnt_q <= 3'd0;
      end
    end
  end

  AST_DONE_AFTER_HELD_J: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (line_i == LS_J) && ($past(line_i) == LS_J)); // R5
endmodule

// File: rtl/uhs_hs_fsm.sv
module uhs_hs_fsm
  import uhs_pkg::*;
#(
  parameter int SUSP_SE0_CYC = 4,
  parameter int FS_SE0_CYC   = 12,
  parameter int HS_SE0_CYC   = 40,
  parameter int SAMPLE_CYC   = 16,
  parameter int CHIRP_CYC    = 30,
  parameter int FALLBACK_CYC = 50,
  parameter int RW           = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    line_i,
  input  logic          susp_i,
  input  logic [RW-1:0] se0_nx_i,
  input  logic          det_done_i,
  output logic          det_en_o,
  output logic          chirp_o,
  output logic          hs_o,
  output logic          reset_o
);
  localparam int TM1  = (CHIRP_CYC > FALLBACK_CYC) ? CHIRP_CYC : FALLBACK_CYC;
  localparam int TMAX = (TM1 > SAMPLE_CYC) ? TM1 : SAMPLE_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  hs_st_e        st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          rst_q, rst_d;
  logic          is_se0, fs_hit, hs_hit;

  assign is_se0 = (line_i == LS_SE0);
  assign fs_hit = is_se0 &&
                  (se0_nx_i == (susp_i ? RW'(SUSP_SE0_CYC) : RW'(FS_SE0_CYC)));
  assign hs_hit = is_se0 && (se0_nx_i == RW'(HS_SE0_CYC));

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    rst_d = 1'b0;
    unique case (st_q)
      ST_FS_IDLE: if (fs_hit) begin
        st_d = ST_CHIRP; tmr_d = '0; rst_d = 1'b1;
      end
      ST_CHIRP: if (tmr_q == TW'(CHIRP_CYC - 1)) begin
        st_d = ST_WAIT_HOST; tmr_d = '0;
      end else tmr_d = tmr_q + 1'b1;
      ST_WAIT_HOST: if (det_done_i) st_d = ST_HS_IDLE;
        else if (tmr_q == TW'(FALLBACK_CYC - 1)) st_d = ST_FS_IDLE;
        else tmr_d = tmr_q + 1'b1;
      ST_HS_IDLE: if (hs_hit) begin
        st_d = ST_REVERT; tmr_d = '0;
      end
      ST_REVERT: if (tmr_q == TW'(SAMPLE_CYC - 1)) begin
        if (is_se0) begin
          st_d = ST_CHIRP; tmr_d = '0; rst_d = 1'b1;
        end else st_d = ST_FS_IDLE;
      end else tmr_d = tmr_q + 1'b1;
      default: st_d = ST_FS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st_q  <= ST_FS_IDLE;
      tmr_q <= '0;
      rst_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      rst_q <= rst_d;
    end
  end

  assign det_en_o = (st_q == ST_WAIT_HOST);
  assign chirp_o  = (st_q == ST_CHIRP);
  assign hs_o     = (st_q == ST_HS_IDLE);
  assign reset_o  = rst_q;

  AST_HS_NEEDS_HOST_TRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_o) |-> $past(det_done_i)); // R5
endmodule

// File: rtl/uhs_upstream_hs.sv
module uhs_upstream_hs
  import uhs_pkg::*;
#(
  parameter int SUSP_SE0_CYC = 4,
  parameter int FS_SE0_CYC   = 12,
  parameter int HS_SE0_CYC   = 40,
  parameter int SAMPLE_CYC   = 16,
  parameter int CHIRP_CYC    = 30,
  parameter int FILT_CYC     = 4,
  parameter int FALLBACK_CYC = 50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] line_st_i,
  input  logic       suspended_i,
  output logic       chirp_k_o,
  output logic       hs_mode_o,
  output logic       bus_reset_o
);
  localparam int THR1    = (SUSP_SE0_CYC > FS_SE0_CYC) ? SUSP_SE0_CYC : FS_SE0_CYC;
  localparam int THR_MAX = (THR1 > HS_SE0_CYC) ? THR1 : HS_SE0_CYC;
  localparam int SE0_SAT = THR_MAX + 1;
  localparam int RW      = $clog2(SE0_SAT + 1);
  localparam int CKW     = $clog2(CHIRP_CYC + 2);

  logic [RW-1:0] se0_nx;
  logic          det_en, det_done;

  uhs_se0_timer #(.CNT_MAX(SE0_SAT), .W(RW)) u_se0 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .is_se0_i (line_st_i == LS_SE0),
    .run_nx_o (se0_nx)
  );

  uhs_chirp_seq #(.FILT_CYC(FILT_CYC)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (det_en),
    .line_i (line_st_i),
    .done_o (det_done)
  );

  uhs_hs_fsm #(
    .SUSP_SE0_CYC (SUSP_SE0_CYC),
    .FS_SE0_CYC   (FS_SE0_CYC),
    .HS_SE0_CYC   (HS_SE0_CYC),
    .SAMPLE_CYC   (SAMPLE_CYC),
    .CHIRP_CYC    (CHIRP_CYC),
    .FALLBACK_CYC (FALLBACK_CYC),
    .RW           (RW)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_i     (line_st_i),
    .susp_i     (suspended_i),
    .se0_nx_i   (se0_nx),
    .det_done_i (det_done),
    .det_en_o   (det_en),
    .chirp_o    (chirp_k_o),
    .hs_o       (hs_mode_o),
    .reset_o    (bus_reset_o)
  );

  // observed chirp length, used by the checks below
  logic [CKW-1:0] ck_run;
  always_ff @(posedge clk_i) begin
    if (!rst_ni)        ck_run <= '0;
    else if (chirp_k_o) ck_run <= (ck_run == CKW'(CHIRP_CYC + 1)) ? ck_run : ck_run + 1'b1;
    else                ck_run <= '0;
  end

  AST_CHIRP_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ck_run <= CKW'(CHIRP_CYC)); // R4
  AST_CHIRP_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(chirp_k_o) |-> ck_run == CKW'(CHIRP_CYC)); // R4
  AST_RESET_AT_CHIRP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chirp_k_o) |-> bus_reset_o); // R4
  AST_RESET_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_o |=> !bus_reset_o); // R4
  AST_NO_CHIRP_IN_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_mode_o && chirp_k_o)); // R5
  AST_HS_EXIT_ON_SE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs_mode_o) |-> $past(line_st_i) == LS_SE0); // R8
endmodule

// File: tb/sim_uhs_upstream_hs.sv
module sim_uhs_upstream_hs;
  localparam int SUSP = 4, FSW = 12, HSW = 40, SAMP = 16, CHIRP = 30, FILT = 4, FALL = 50;
  localparam int SAT = HSW + 1;
  localparam logic [1:0] SE0 = 2'b00, J = 2'b01, K = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0, susp = 1'b0;
  logic [1:0] line = J;
  logic chirp_k, hs_mode, bus_reset;

  always #10 clk = ~clk;

  uhs_upstream_hs #(.SUSP_SE0_CYC(SUSP), .FS_SE0_CYC(FSW), .HS_SE0_CYC(HSW),
    .SAMPLE_CYC(SAMP), .CHIRP_CYC(CHIRP), .FILT_CYC(FILT), .FALLBACK_CYC(FALL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .line_st_i(line), .suspended_i(susp),
    .chirp_k_o(chirp_k), .hs_mode_o(hs_mode), .bus_reset_o(bus_reset));

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: phase 0 fs idle, 1 chirp, 2 listen, 3 hs, 4 revert
  int m_ph = 0, m_t = 0, m_se0 = 0, m_rst = 0;
  int m_seg = 3, m_hold = 0, m_pairs = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_t = 0; m_se0 = 0; m_rst = 0; m_seg = 3; m_hold = 0; m_pairs = 0;
    end else begin
      int old_ph, nse0, want, nrst;
      bit qual, done, is0;
      old_ph = m_ph;
      is0 = (line == SE0);
      nse0 = is0 ? ((m_se0 >= SAT) ? SAT : m_se0 + 1) : 0;
      want = (m_pairs % 2 == 1) ? J : K;
      qual = (old_ph == 2) && (int'(line) == m_seg) && (m_hold == FILT - 1);
      done = qual && (int'(line) == want) && (m_pairs == 5);
      nrst = 0;
      case (old_ph)
        0: if (is0 && nse0 == (susp ? SUSP : FSW)) begin m_ph = 1; m_t = 0; nrst = 1; end
        1: if (m_t == CHIRP - 1) begin m_ph = 2; m_t = 0; end else m_t++;
        2: if (done) m_ph = 3; else if (m_t == FALL - 1) m_ph = 0; else m_t++;
        3: if (is0 && nse0 == HSW) begin m_ph = 4; m_t = 0; end
        4: if (m_t == SAMP - 1) begin
             if (is0) begin m_ph = 1; m_t = 0; nrst = 1; end else m_ph = 0;
           end else m_t++;
        default: m_ph = 0;
      endcase
      if (old_ph != 2) begin
        m_seg = 3; m_hold = 0; m_pairs = 0;
      end else begin
        if (qual) begin
          if (int'(line) == want) m_pairs++;
          else m_pairs = (line == K) ? 1 : 0;
        end
        if (int'(line) != m_seg) begin m_seg = line; m_hold = 1; end
        else if (m_hold < FILT) m_hold++;
      end
      m_se0 = nse0;
      m_rst = nrst;
    end
  end

  int n_rst = 0, ck_len = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(chirp_k == (m_ph == 1) && hs_mode == (m_ph == 3) && bus_reset == (m_rst == 1),
            cur_req, "outputs {chirp,hs,rst} vs model",
            {chirp_k, hs_mode, bus_reset},
            {(m_ph == 1), (m_ph == 3), (m_rst == 1)});
      if (bus_reset) n_rst++;
      if (chirp_k) ck_len++;
      else if (ck_len != 0) begin
        check(ck_len == CHIRP, "R4", "chirp length", ck_len, CHIRP);
        ck_len = 0;
      end
    end
  end

  task automatic hold(input logic [1:0] ls, input int n);
    line = ls;
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(0, "WDOG", "watchdog expired", 0, 1);
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(!chirp_k && !hs_mode && !bus_reset, "R1", "outputs in reset",
          {chirp_k, hs_mode, bus_reset}, 0);
    rst_n = 1'b1;
    hold(J, 5);
    check(!chirp_k && !hs_mode && !bus_reset, "R1", "outputs after reset",
          {chirp_k, hs_mode, bus_reset}, 0);

    cur_req = "R3";
    hold(SE0, SUSP); hold(J, 5);
    check(n_rst == 0 && !chirp_k, "R3", "short SE0 when awake ignored", n_rst, 0);
    hold(SE0, FSW - 1);
    check(!chirp_k, "R3", "no chirp before threshold", chirp_k, 0);
    hold(SE0, 1);
    check(chirp_k && bus_reset, "R3", "reset at full-speed threshold",
          {chirp_k, bus_reset}, 3);

    cur_req = "R4";
    hold(K, CHIRP - 1);
    check(chirp_k && !bus_reset, "R4", "chirp held, pulse gone", {chirp_k, bus_reset}, 2);
    hold(K, 1);
    check(!chirp_k, "R4", "chirp ended", chirp_k, 0);

    cur_req = "R7";
    hold(SE0, 60);
    check(!hs_mode && !chirp_k && n_rst == 1, "R7", "fallback, no re-trigger", n_rst, 1);

    cur_req = "R2";
    hold(J, 5);
    susp = 1'b1;
    hold(SE0, SUSP);
    check(bus_reset && chirp_k, "R2", "suspended reset after short SE0",
          {chirp_k, bus_reset}, 3);
    susp = 1'b0;

    cur_req = "R5";
    hold(K, CHIRP);
    hold(K, 5); hold(J, 5); hold(K, 5); hold(J, 5); hold(K, 5); hold(J, FILT - 1);
    check(!hs_mode, "R5", "hs not before final J qualified", hs_mode, 0);
    hold(J, 1);
    check(hs_mode && !chirp_k, "R5", "hs entered after train", hs_mode, 1);

    cur_req = "R9";
    hold(SE0, 30); hold(K, 2); hold(SE0, 30);
    check(hs_mode, "R9", "activity restarts SE0 count", hs_mode, 1);

    cur_req = "R8";
    hold(SE0, HSW - 30);
    check(!hs_mode, "R8", "revert after HS SE0 window", hs_mode, 0);
    hold(SE0, SAMP - 1);
    check(!chirp_k && n_rst == 2, "R8", "no action before sample point", n_rst, 2);
    hold(SE0, 1);
    check(chirp_k && bus_reset, "R8", "SE0 at sample means reset", {chirp_k, bus_reset}, 3);

    cur_req = "R6";
    hold(K, CHIRP);
    hold(K, 5); hold(J, 5); hold(K, 5); hold(J, FILT - 2);
    hold(K, 5); hold(J, 5); hold(K, 5); hold(J, 5);
    check(!hs_mode, "R6", "short J glitch restarts train", hs_mode, 0);
    hold(K, 5); hold(J, 5);
    check(hs_mode, "R6", "hs after restarted train", hs_mode, 1);

    cur_req = "R8";
    hold(SE0, HSW);
    check(!hs_mode, "R8", "revert on long SE0", hs_mode, 0);
    hold(J, SAMP);
    hold(J, 20);
    check(!hs_mode && !chirp_k && n_rst == 3, "R8", "J at sample means suspend", n_rst, 3);

    finished = 1;
    summary();
  end
endmodule